// File: doc/BRIEF.md
# Condition-Code Next-PC Unit

This block chooses the address of the next instruction for a 16-bit, word-addressed processor. Each cycle it receives the current program counter, a decoded transfer kind, an immediate field, a register value and a condition mask. From these it produces the next PC, a taken flag and, for calls, a return address with a write strobe for the link register. Nothing is registered on the address path, so the next PC is ready in the same cycle.

The block also holds the condition-code flags. When the datapath finishes an ALU or compare operation, it presents the 16-bit result with a write strobe. The flags then record whether that result was negative, zero or positive. Later conditional branches test these flags through a three-bit mask.

A conditional branch always tests the flags as they were stored before the current clock edge. A flag write in the same cycle affects only later branches.

Top module: `cc_nextpc_unit`

## Requirements
- R1: With transfer kind 0 (sequential), and for unknown kinds 6 and 7, next_pc_o is pc_i+1 modulo 2^16 and taken_o is 0.
- R2: With kind 1 (branch), the target is pc_i+1 plus the sign-extended low 9 bits of imm_i, modulo 2^16. The branch is taken when (nzp_mask_i & cc_o) is nonzero; otherwise next_pc_o is pc_i+1.
- R3: A branch mask of 000 never branches, whatever the flags hold.
- R4: With kind 2 (jump), next_pc_o is pc_i+1 plus the sign-extended 11-bit imm_i, modulo 2^16, and taken_o is 1.
- R5: With kind 3 (call), next_pc_o is {pc_i[15], imm_i[10:0], 4'b0000}. The low four bits are therefore always zero.
- R6: With kind 4 (return), next_pc_o equals reg_tgt_i and no link write occurs. With kind 5 (indirect call), next_pc_o equals reg_tgt_i and a link write occurs.
- R7: link_wr_o is 1 exactly for kinds 3 and 5, and then link_addr_o is pc_i+1 modulo 2^16.
- R8: cc_o is {N,Z,P} in bits [2:0] and exactly one bit is set. Reset leaves 3'b010 (Z).
- R9: A clock edge with cc_wr_i high stores flags from cc_result_i read as two's complement: 100 if negative, 010 if zero, 001 if positive.
- R10: A clock edge with cc_wr_i low leaves cc_o unchanged, whatever cc_result_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flags |
| pc_i | input | 16 | Current program counter |
| xfer_kind_i | input | 3 | Transfer kind: 0 seq, 1 branch, 2 jump, 3 call, 4 return, 5 indirect call |
| imm_i | input | 11 | Offset or absolute call field |
| nzp_mask_i | input | 3 | Branch condition mask, bits {N,Z,P} |
| reg_tgt_i | input | 16 | Register value used as the indirect target |
| cc_wr_i | input | 1 | Update the flags at this edge |
| cc_result_i | input | 16 | Result the flags are taken from |
| next_pc_o | output | 16 | Selected next PC |
| taken_o | output | 1 | Control leaves the sequential path |
| link_wr_o | output | 1 | Write strobe for the link register |
| link_addr_o | output | 16 | Return address (pc_i+1) |
| cc_o | output | 3 | Stored flags {N,Z,P} |

## Verification
The assertions assume the following about the inputs:
- reset is applied before the flags are used;
- the flags change only through the write strobe;
- the address inputs are known values in every sampled cycle.

The stimulus applies reset first and sets the flags only through cc_wr_i, with writes spread over whole clock periods. It keeps the strobe low during the target sweeps, so the flags a branch sees are the ones the bench last wrote. All inputs change on the falling edge, so every clocked check sees settled values.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
   typedef enum logic [2:0] {
      XK_SEQ    = 3'd0,
      XK_BRANCH = 3'd1,
      XK_JUMP   = 3'd2,
      XK_CALL   = 3'd3,
      XK_RET    = 3'd4,
      XK_ICALL  = 3'd5
   } xfer_kind_e;

   localparam int FLAG_N = 2;
   localparam int FLAG_Z = 1;
   localparam int FLAG_P = 0;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/nextpc_sext.sv
module nextpc_sext #(
   parameter int IN_W  = 9,
   parameter int OUT_W = 16
) (
   input  logic [IN_W-1:0]  val_i,
   output logic [OUT_W-1:0] val_o
);
   if (IN_W > OUT_W) begin : g_bad_width
      $error("nextpc_sext: IN_W must not exceed OUT_W");
   end

   if (IN_W == OUT_W) begin : g_pass
      assign val_o = val_i;
   end else begin : g_extend
      localparam int PAD_W = OUT_W - IN_W;
      assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
   end
endmodule

// File: rtl/nextpc_ccreg.sv
module nextpc_ccreg #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] result_i,
   output logic [2:0]        cc_o
);
   import nextpc_pkg::*;

   logic [2:0] cc_q;
   logic [2:0] cc_d;
   logic       is_neg;
   logic       is_zero;

   assign is_neg  = result_i[DATA_W-1];
   assign is_zero = (result_i == '0);

   always_comb begin
      cc_d = '0;
      if (is_neg)       cc_d[FLAG_N] = 1'b1;
      else if (is_zero) cc_d[FLAG_Z] = 1'b1;
      else              cc_d[FLAG_P] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cc_q <= 3'b010;
      else if (wr_i) cc_q <= cc_d;
   end

   assign cc_o = cc_q;

   // R8: exactly one flag is held
   a_r8_cc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cc_o) == 1);

   // R9: a write stores the sign class of the presented result
   a_r9_cc_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (cc_o[FLAG_N] == $past(result_i[DATA_W-1]))
               && (cc_o[FLAG_Z] == ($past(result_i) == '0)));

   // R10: without a write the flags stay put
   a_r10_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(cc_o));
endmodule

// File: rtl/nextpc_targets.sv
module nextpc_targets #(
   parameter int ADDR_W      = 16,
   parameter int BR_OFS_W    = 9,
   parameter int JMP_OFS_W   = 11,
   parameter int CALL_FLD_W  = 11,
   parameter int ALIGN_LOG2  = 4,
   parameter int IMM_W       = 11
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [ADDR_W-1:0] seq_o,
   output logic [ADDR_W-1:0] br_o,
   output logic [ADDR_W-1:0] jmp_o,
   output logic [ADDR_W-1:0] call_o
);
   localparam int KEEP_W = ADDR_W - CALL_FLD_W - ALIGN_LOG2;

   logic [ADDR_W-1:0] br_ofs;
   logic [ADDR_W-1:0] jmp_ofs;

   nextpc_sext #(.IN_W(BR_OFS_W), .OUT_W(ADDR_W)) u_br_sext (
      .val_i(imm_i[BR_OFS_W-1:0]),
      .val_o(br_ofs)
   );

   nextpc_sext #(.IN_W(JMP_OFS_W), .OUT_W(ADDR_W)) u_jmp_sext (
      .val_i(imm_i[JMP_OFS_W-1:0]),
      .val_o(jmp_ofs)
   );

   assign seq_o = pc_i + ADDR_W'(1);
   assign br_o  = seq_o + br_ofs;
   assign jmp_o = seq_o + jmp_ofs;

   if (KEEP_W > 0 && ALIGN_LOG2 > 0) begin : g_call_keep_align
      assign call_o = {pc_i[ADDR_W-1 -: KEEP_W], imm_i[CALL_FLD_W-1:0],
                       {ALIGN_LOG2{1'b0}}};
   end else if (KEEP_W > 0) begin : g_call_keep
      assign call_o = {pc_i[ADDR_W-1 -: KEEP_W], imm_i[CALL_FLD_W-1:0]};
   end else if (ALIGN_LOG2 > 0) begin : g_call_align
      assign call_o = {imm_i[CALL_FLD_W-1:0], {ALIGN_LOG2{1'b0}}};
   end else begin : g_call_plain
      assign call_o = imm_i[CALL_FLD_W-1:0];
   end
endmodule

// File: rtl/nextpc_cond.sv
module nextpc_cond (
   input  logic [2:0] mask_i,
   input  logic [2:0] cc_i,
   output logic       hit_o
);
   assign hit_o = |(mask_i & cc_i);
endmodule

// File: rtl/cc_nextpc_unit.sv
module cc_nextpc_unit #(
   parameter int ADDR_W     = 16,
   parameter int BR_OFS_W   = 9,
   parameter int JMP_OFS_W  = 11,
   parameter int CALL_FLD_W = 11,
   parameter int ALIGN_LOG2 = 4,
   parameter int IMM_W      = nextpc_pkg::max3(BR_OFS_W, JMP_OFS_W, CALL_FLD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [2:0]        xfer_kind_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [2:0]        nzp_mask_i,
   input  logic [ADDR_W-1:0] reg_tgt_i,
   input  logic              cc_wr_i,
   input  logic [ADDR_W-1:0] cc_result_i,
   output logic [ADDR_W-1:0] next_pc_o,
   output logic              taken_o,
   output logic              link_wr_o,
   output logic [ADDR_W-1:0] link_addr_o,
   output logic [2:0]        cc_o
);
   import nextpc_pkg::*;

   if (CALL_FLD_W + ALIGN_LOG2 > ADDR_W) begin : g_bad_call
      $error("cc_nextpc_unit: call field plus alignment exceeds ADDR_W");
   end
   if (BR_OFS_W < 2 || JMP_OFS_W < 2) begin : g_bad_ofs
      $error("cc_nextpc_unit: offsets need at least two bits");
   end

   logic [ADDR_W-1:0] seq_pc, br_pc, jmp_pc, call_pc;
   logic              cond_hit;
   xfer_kind_e        kind;

   assign kind = xfer_kind_e'(xfer_kind_i);

   nextpc_ccreg #(.DATA_W(ADDR_W)) u_ccreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (cc_wr_i),
      .result_i (cc_result_i),
      .cc_o     (cc_o)
   );

   nextpc_targets #(
      .ADDR_W     (ADDR_W),
      .BR_OFS_W   (BR_OFS_W),
      .JMP_OFS_W  (JMP_OFS_W),
      .CALL_FLD_W (CALL_FLD_W),
      .ALIGN_LOG2 (ALIGN_LOG2),
      .IMM_W      (IMM_W)
   ) u_targets (
      .pc_i   (pc_i),
      .imm_i  (imm_i),
      .seq_o  (seq_pc),
      .br_o   (br_pc),
      .jmp_o  (jmp_pc),
      .call_o (call_pc)
   );

   nextpc_cond u_cond (
      .mask_i (nzp_mask_i),
      .cc_i   (cc_o),
      .hit_o  (cond_hit)
   );

   always_comb begin
      next_pc_o = seq_pc;
      taken_o   = 1'b0;
      link_wr_o = 1'b0;
      unique case (kind)
         XK_BRANCH: begin
            if (cond_hit) begin
               next_pc_o = br_pc;
               taken_o   = 1'b1;
            end
         end
         XK_JUMP: begin
            next_pc_o = jmp_pc;
            taken_o   = 1'b1;
         end
         XK_CALL: begin
            next_pc_o = call_pc;
            taken_o   = 1'b1;
            link_wr_o = 1'b1;
         end
         XK_RET: begin
            next_pc_o = reg_tgt_i;
            taken_o   = 1'b1;
         end
         XK_ICALL: begin
            next_pc_o = reg_tgt_i;
            taken_o   = 1'b1;
            link_wr_o = 1'b1;
         end
         default: ;
      endcase
   end

   assign link_addr_o = seq_pc;

   // R1: sequential flow steps by one word
   a_r1_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_kind_i == 3'd0) |-> (next_pc_o == pc_i + ADDR_W'(1)) && !taken_o);

   // R3: an empty mask never branches
   a_r3_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_kind_i == 3'd1 && nzp_mask_i == 3'b000) |-> !taken_o);

   // R5: call target is aligned and keeps the PC's upper region
   a_r5_call_align: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_kind_i == 3'd3) |->
         (next_pc_o[ALIGN_LOG2 > 0 ? ALIGN_LOG2-1 : 0:0] == '0 || ALIGN_LOG2 == 0)
         && (next_pc_o[ADDR_W-1] == pc_i[ADDR_W-1]
             || CALL_FLD_W + ALIGN_LOG2 == ADDR_W));

   // R7: link strobe only on call kinds, carrying the return address
   a_r7_link: assert property (@(posedge clk) disable iff (!rst_n)
      link_wr_o |-> (xfer_kind_i == 3'd3 || xfer_kind_i == 3'd5)
                    && (link_addr_o == pc_i + ADDR_W'(1)));

   // R6: return kinds follow the register target
   a_r6_indirect: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_kind_i == 3'd4 || xfer_kind_i == 3'd5) |-> next_pc_o == reg_tgt_i);
endmodule

// File: tb/cc_nextpc_unit_bench.sv
module cc_nextpc_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pc_i = '0;
   logic [2:0]  xfer_kind_i = '0;
   logic [10:0] imm_i = '0;
   logic [2:0]  nzp_mask_i = '0;
   logic [15:0] reg_tgt_i = '0;
   logic        cc_wr_i = 1'b0;
   logic [15:0] cc_result_i = '0;
   logic [15:0] next_pc_o;
   logic        taken_o;
   logic        link_wr_o;
   logic [15:0] link_addr_o;
   logic [2:0]  cc_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cc_nextpc_unit u_cc_nextpc_unit (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .xfer_kind_i(xfer_kind_i),
      .imm_i(imm_i), .nzp_mask_i(nzp_mask_i), .reg_tgt_i(reg_tgt_i),
      .cc_wr_i(cc_wr_i), .cc_result_i(cc_result_i), .next_pc_o(next_pc_o),
      .taken_o(taken_o), .link_wr_o(link_wr_o), .link_addr_o(link_addr_o),
      .cc_o(cc_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int flags_of(input int v);
      if (v[15]) return 4;
      if ((v & 16'hFFFF) == 0) return 2;
      return 1;
   endfunction

   function automatic int sx(input int v, input int w);
      int m;
      m = v & ((1 << w) - 1);
      if (m >= (1 << (w - 1))) m = m - (1 << w);
      return m;
   endfunction

   task automatic write_cc(input int v);
      @(negedge clk);
      cc_wr_i = 1'b1;
      cc_result_i = 16'(v);
      @(negedge clk);
      cc_wr_i = 1'b0;
      cc_result_i = 16'(~v);
      #2;
      chk("R9 flag write", int'(cc_o), flags_of(v));
   endtask

   task automatic apply(input int kind, input int pc, input int imm,
                        input int mask, input int rt);
      @(negedge clk);
      xfer_kind_i = 3'(kind);
      pc_i = 16'(pc);
      imm_i = 11'(imm);
      nzp_mask_i = 3'(mask);
      reg_tgt_i = 16'(rt);
      #2;
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int pcs[6];
      int imms[7];
      pcs = '{0, 1, 16'h7FFF, 16'h8000, 16'h1234, 16'hFFFF};
      imms = '{0, 1, 255, 256, 511, 1023, 1024};

      repeat (3) @(negedge clk);
      #2;
      chk("R8 reset flags", int'(cc_o), 2);
      rst_n = 1'b1;

      // R9 write of each class, R10 hold
      write_cc(16'h8000);
      write_cc(0);
      write_cc(16'h7FFF);
      write_cc(16'hFFFF);
      write_cc(5);
      @(negedge clk);
      cc_result_i = 16'h8001;
      @(negedge clk);
      #2;
      chk("R10 hold without write", int'(cc_o), 1);

      // R1 sequential and unknown kinds
      foreach (pcs[i]) begin
         for (int k = 0; k < 8; k++) begin
            if (k == 0 || k == 6 || k == 7) begin
               apply(k, pcs[i], 11'h5A5, 7, 16'hBEEF);
               chk("R1 seq next", int'(next_pc_o), (pcs[i] + 1) & 16'hFFFF);
               chk("R1 seq taken", int'(taken_o), 0);
               chk("R7 no link", int'(link_wr_o), 0);
            end
         end
      end

      // R2/R3: every flag state against every mask
      for (int c = 0; c < 3; c++) begin
         int res;
         int fl;
         res = (c == 0) ? 16'hFFF0 : ((c == 1) ? 0 : 9);
         write_cc(res);
         fl = flags_of(res);
         for (int m = 0; m < 8; m++) begin
            foreach (pcs[i]) begin
               foreach (imms[j]) begin
                  int tk;
                  int exp;
                  apply(1, pcs[i], imms[j], m, 0);
                  tk = ((m & fl) != 0) ? 1 : 0;
                  exp = tk ? ((pcs[i] + 1 + sx(imms[j], 9)) & 16'hFFFF)
                           : ((pcs[i] + 1) & 16'hFFFF);
                  if (m == 0) chk("R3 empty mask", int'(taken_o), 0);
                  else chk("R2 branch taken", int'(taken_o), tk);
                  chk("R2 branch next", int'(next_pc_o), exp);
               end
            end
         end
      end

      // R4 jump, R5 call, R6 indirect, R7 link
      foreach (pcs[i]) begin
         for (int im = 0; im < 2048; im += 37) begin
            apply(2, pcs[i], im, 0, 0);
            chk("R4 jump next", int'(next_pc_o),
                (pcs[i] + 1 + sx(im, 11)) & 16'hFFFF);
            chk("R4 jump taken", int'(taken_o), 1);
            apply(3, pcs[i], im, 0, 0);
            chk("R5 call next", int'(next_pc_o),
                (pcs[i] & 16'h8000) | ((im & 11'h7FF) << 4));
            chk("R7 call link", int'(link_wr_o), 1);
            chk("R7 call addr", int'(link_addr_o), (pcs[i] + 1) & 16'hFFFF);
         end
         apply(2, pcs[i], 11'h3FF, 0, 0);
         chk("R4 max fwd", int'(next_pc_o), (pcs[i] + 1 + 1023) & 16'hFFFF);
         apply(2, pcs[i], 11'h400, 0, 0);
         chk("R4 max back", int'(next_pc_o), (pcs[i] + 1 - 1024) & 16'hFFFF);
         apply(4, pcs[i], 3, 7, pcs[i] ^ 16'h5A5A);
         chk("R6 return next", int'(next_pc_o), pcs[i] ^ 16'h5A5A);
         chk("R6 return no link", int'(link_wr_o), 0);
         apply(5, pcs[i], 3, 7, pcs[i] ^ 16'hA5A5);
         chk("R6 icall next", int'(next_pc_o), pcs[i] ^ 16'hA5A5);
         chk("R7 icall link", int'(link_wr_o), 1);
         chk("R7 icall addr", int'(link_addr_o), (pcs[i] + 1) & 16'hFFFF);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule